// File: doc/BRIEF.md
# Bridge Legacy-Aware Forwarding Decoder

This block makes the claim decision for a two-sided bridge. Each request carries an address, a space flag (memory or I/O) and the side it arrived on: upstream or downstream. The block answers whether the bridge should forward the request to the opposite side, and why. Ordinary forwarding uses one inclusive base/limit window per space. A request from the upstream side that hits the window is passed down. A request from the downstream side that misses the window is passed up.

A legacy display range sits on top of the windows. When the display-enable control bit is set, this range is always claimed downstream, whatever the windows hold. The range is a 128 KB memory hole plus two small I/O groups, and the I/O groups match at every 1 KB alias. The same range is never passed upward from the downstream side. A small write-only register port loads the enable bits and the windows.

A two-state machine runs the response path. `ST_IDLE` means no response is on the outputs. `ST_RESP` means a response is on the outputs for this cycle. The transitions are as follows. The *take* transition goes from ST_IDLE to ST_RESP on `req_valid`. The *repeat* transition stays in ST_RESP while requests come back to back. The *drain* transition goes from ST_RESP to ST_IDLE when no request arrives. The machine waits in ST_IDLE while there are no requests.

Top module: `bridge_fwd_decoder`

## Requirements
- R1: Bridge-control register index 1 holds the display-enable bit at bit 3, and this bit is 0 after reset. Directly after reset, a legacy-range request from the upstream side that lies outside the windows is not forwarded.
- R2: A request seen at a clock edge with `req_valid` high gives `rsp_valid` high during the following cycle only, carrying that request's decision. Back-to-back requests give back-to-back responses. With no request, `rsp_valid`, `rsp_forward` and `rsp_reason` are all 0. Reason codes are: 0 none, 1 window, 2 legacy memory, 3 legacy I/O. `rsp_forward` is 1 exactly when the reason is nonzero.
- R3: With display-enable set and memory enable set, an upstream-side memory request with address 0x000A0000..0x000BFFFF is forwarded with reason 2, whatever the memory window holds.
- R4: With display-enable set and I/O enable set, an upstream-side I/O request is forwarded with reason 3 when address bits 31:16 are zero and bits 9:0 lie in 0x3B0..0x3BB or 0x3C0..0x3DF. Bits 15:10 take any value.
- R5: Command register index 0 holds I/O enable at bit 0 and memory enable at bit 1. Downstream forwarding of a space, legacy or window, happens only when that space's enable bit is 1.
- R6: With display-enable set, a downstream-side request in the legacy range of its space is not forwarded (reason 0), even when it lies outside the window.
- R7: With display-enable clear, legacy-range addresses are decoded only by the window of their space.
- R8: Register indices 2/3 hold the I/O base/limit and 4/5 hold the memory base/limit. An upstream-side request with base <= address <= limit in its space's window is forwarded with reason 1.
- R9: A downstream-side request outside its space's window, and not blocked by R6, is forwarded with reason 1. Inside the window it is not forwarded.
- R10: A window whose base is greater than its limit is empty. Such a window never gives reason 1 for upstream-side requests, and every non-legacy downstream-side request of that space is forwarded. The reset values are base all-ones and limit zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_idx | input | 3 | Register index (0 command, 1 bridge control, 2..5 windows) |
| cfg_wdata | input | 32 | Register write data |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 32 | Request address |
| req_is_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_from_sec | input | 1 | 1 = arrived on downstream side, 0 = upstream side |
| rsp_valid | output | 1 | Decision valid this cycle |
| rsp_forward | output | 1 | Forward to the opposite side |
| rsp_reason | output | 2 | 0 none, 1 window, 2 legacy memory, 3 legacy I/O |

## Verification
A wrong stored enable or window value stays hidden until a request tests that value. It then shows as a wrong `rsp_forward` or `rsp_reason` exactly one cycle after that request. A state machine stuck in ST_RESP, or one that never leaves ST_IDLE, shows in the first cycle after a gap or after a request, as a wrong `rsp_valid`. The bench therefore sweeps every low-ten-bit I/O offset across varied alias bits and both sides. It also steps through memory addresses around the legacy hole and window edges. Each response is compared in the cycle after it is requested.

// File: rtl/bfd_pkg.sv
package bfd_pkg;
    typedef enum logic [1:0] {
        RSN_NONE    = 2'd0,
        RSN_WINDOW  = 2'd1,
        RSN_VGA_MEM = 2'd2,
        RSN_VGA_IO  = 2'd3
    } reason_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } state_e;

    localparam int REG_CMD      = 0;
    localparam int REG_BRCTL    = 1;
    localparam int REG_IO_BASE  = 2;
    localparam int REG_IO_LIM   = 3;
    localparam int REG_MEM_BASE = 4;
    localparam int REG_MEM_LIM  = 5;

    localparam int CMD_IO_BIT   = 0;
    localparam int CMD_MEM_BIT  = 1;
    localparam int BRCTL_VGA_BIT = 3;

    localparam logic [31:0] LEG_MEM_LO = 32'h000A_0000;
    localparam logic [31:0] LEG_MEM_HI = 32'h000B_FFFF;
    localparam logic [9:0]  LEG_IO_A_LO = 10'h3B0;
    localparam logic [9:0]  LEG_IO_A_HI = 10'h3BB;
    localparam logic [9:0]  LEG_IO_B_LO = 10'h3C0;
    localparam logic [9:0]  LEG_IO_B_HI = 10'h3DF;
endpackage

// File: rtl/bfd_cfg_regs.sv
module bfd_cfg_regs #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [ADDR_W-1:0] wdata,
    output logic              io_en,
    output logic              mem_en,
    output logic              vga_en,
    output logic [ADDR_W-1:0] io_base,
    output logic [ADDR_W-1:0] io_limit,
    output logic [ADDR_W-1:0] mem_base,
    output logic [ADDR_W-1:0] mem_limit
);
    import bfd_pkg::*;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            io_en     <= 1'b0;
            mem_en    <= 1'b0;
            vga_en    <= 1'b0;
            io_base   <= '1;
            io_limit  <= '0;
            mem_base  <= '1;
            mem_limit <= '0;
        end else if (we) begin
            unique case (int'(idx))
                REG_CMD: begin
                    io_en  <= wdata[CMD_IO_BIT];
                    mem_en <= wdata[CMD_MEM_BIT];
                end
                REG_BRCTL:    vga_en    <= wdata[BRCTL_VGA_BIT];
                REG_IO_BASE:  io_base   <= wdata;
                REG_IO_LIM:   io_limit  <= wdata;
                REG_MEM_BASE: mem_base  <= wdata;
                REG_MEM_LIM:  mem_limit <= wdata;
                default: ;
            endcase
        end
    end

    AST_VGA_EN_RESET: assert property (@(posedge clk)
        !rst_n |=> !vga_en); // R1
endmodule

// File: rtl/bfd_vga_match.sv
module bfd_vga_match #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              mem_hit,
    output logic              io_hit
);
    import bfd_pkg::*;

    logic [9:0] low10;
    logic       upper_zero;
    logic       unused_alias_bits;

    assign low10             = addr[9:0];
    assign upper_zero        = (addr[ADDR_W-1:16] == '0);
    assign unused_alias_bits = ^addr[15:10];

    always_comb begin
        mem_hit = (addr >= ADDR_W'(LEG_MEM_LO)) && (addr <= ADDR_W'(LEG_MEM_HI));
        io_hit  = upper_zero &&
                  (((low10 >= LEG_IO_A_LO) && (low10 <= LEG_IO_A_HI)) ||
                   ((low10 >= LEG_IO_B_LO) && (low10 <= LEG_IO_B_HI)));
    end
endmodule

// File: rtl/bfd_window_cmp.sv
module bfd_window_cmp #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] limit,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    logic open_win;

    always_comb begin
        open_win = (base <= limit);
        hit      = open_win && (addr >= base) && (addr <= limit);
    end
endmodule

// File: rtl/bridge_fwd_decoder.sv
module bridge_fwd_decoder #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_is_io,
    input  logic              req_from_sec,
    output logic              rsp_valid,
    output logic              rsp_forward,
    output logic [1:0]        rsp_reason
);
    import bfd_pkg::*;

    logic              io_en, mem_en, vga_en;
    logic [ADDR_W-1:0] io_base, io_limit, mem_base, mem_limit;
    logic              leg_mem_hit, leg_io_hit;
    logic              io_win_hit, mem_win_hit;

    bfd_cfg_regs #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .idx(cfg_idx), .wdata(cfg_wdata),
        .io_en(io_en), .mem_en(mem_en), .vga_en(vga_en),
        .io_base(io_base), .io_limit(io_limit),
        .mem_base(mem_base), .mem_limit(mem_limit)
    );

    bfd_vga_match #(.ADDR_W(ADDR_W)) u_leg (
        .addr(req_addr), .mem_hit(leg_mem_hit), .io_hit(leg_io_hit)
    );

    bfd_window_cmp #(.ADDR_W(ADDR_W)) u_io_win (
        .base(io_base), .limit(io_limit), .addr(req_addr), .hit(io_win_hit)
    );

    bfd_window_cmp #(.ADDR_W(ADDR_W)) u_mem_win (
        .base(mem_base), .limit(mem_limit), .addr(req_addr), .hit(mem_win_hit)
    );

    // Decision for the request currently presented
    logic    leg_sel, space_en, win_hit;
    logic    dec_fwd;
    reason_e dec_rsn;

    always_comb begin
        leg_sel  = vga_en && (req_is_io ? leg_io_hit : leg_mem_hit);
        space_en = req_is_io ? io_en : mem_en;
        win_hit  = req_is_io ? io_win_hit : mem_win_hit;
        dec_fwd  = 1'b0;
        dec_rsn  = RSN_NONE;
        if (!req_from_sec) begin
            if (leg_sel && space_en) begin
                dec_fwd = 1'b1;
                dec_rsn = req_is_io ? RSN_VGA_IO : RSN_VGA_MEM;
            end else if (win_hit && space_en) begin
                dec_fwd = 1'b1;
                dec_rsn = RSN_WINDOW;
            end
        end else if (!leg_sel && !win_hit) begin
            dec_fwd = 1'b1;
            dec_rsn = RSN_WINDOW;
        end
    end

    // Response state machine
    state_e state_q, state_d;

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = req_valid ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = req_valid ? ST_RESP : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_forward <= 1'b0;
            rsp_reason  <= RSN_NONE;
        end else if (req_valid) begin
            rsp_forward <= dec_fwd;
            rsp_reason  <= dec_rsn;
        end else begin
            rsp_forward <= 1'b0;
            rsp_reason  <= RSN_NONE;
        end
    end

    assign rsp_valid = (state_q == ST_RESP);

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R2
    AST_RSP_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !rsp_forward)); // R2
    AST_FWD_MATCHES_REASON: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_forward == (rsp_reason != RSN_NONE))); // R2
    AST_SEC_LEGACY_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_from_sec && vga_en &&
         (req_is_io ? leg_io_hit : leg_mem_hit)) |=> !rsp_forward); // R6
    AST_MEM_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_from_sec && !req_is_io && !mem_en) |=> !rsp_forward); // R5
    AST_EMPTY_IO_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_from_sec && req_is_io && (io_base > io_limit) && !leg_io_hit)
        |=> (rsp_reason != RSN_WINDOW)); // R10
endmodule

// File: tb/bridge_fwd_decoder_bench.sv
module bridge_fwd_decoder_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_is_io = 1'b0;
    logic        req_from_sec = 1'b0;
    logic        rsp_valid, rsp_forward;
    logic [1:0]  rsp_reason;

    int checks = 0;
    int failures = 0;

    // bench-side copy of what was written
    logic        m_io_en = 0, m_mem_en = 0, m_vga = 0;
    logic [31:0] m_io_base = 32'hFFFF_FFFF, m_io_lim = 0;
    logic [31:0] m_mem_base = 32'hFFFF_FFFF, m_mem_lim = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bridge_fwd_decoder u_bridge_fwd_decoder (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_addr(req_addr),
        .req_is_io(req_is_io), .req_from_sec(req_from_sec),
        .rsp_valid(rsp_valid), .rsp_forward(rsp_forward), .rsp_reason(rsp_reason)
    );

    // expected {forward, reason} from the requirements
    function automatic logic [2:0] model(input logic [31:0] a, input logic io, input logic sec);
        logic vm, vi, en, inw, leg;
        logic [31:0] b, l;
        logic [9:0] lo;
        lo  = a[9:0];
        vm  = !io && a >= 32'h000A_0000 && a <= 32'h000B_FFFF;
        vi  = io && a[31:16] == 16'h0 &&
              ((lo >= 10'h3B0 && lo <= 10'h3BB) || (lo >= 10'h3C0 && lo <= 10'h3DF));
        en  = io ? m_io_en : m_mem_en;
        b   = io ? m_io_base : m_mem_base;
        l   = io ? m_io_lim : m_mem_lim;
        inw = (b <= l) && a >= b && a <= l;
        leg = m_vga && (vm || vi);
        if (!sec) begin
            if (leg && en) return {1'b1, (vi ? 2'd3 : 2'd2)};
            if (inw && en) return 3'b101;
            return 3'b000;
        end
        if (leg) return 3'b000;
        if (!inw) return 3'b101;
        return 3'b000;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input int idx, input logic [31:0] d);
        req_valid = 1'b0;
        cfg_we    = 1'b1;
        cfg_idx   = 3'(idx);
        cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        case (idx)
            0: begin m_io_en = d[0]; m_mem_en = d[1]; end
            1: m_vga = d[3];
            2: m_io_base = d;
            3: m_io_lim = d;
            4: m_mem_base = d;
            5: m_mem_lim = d;
            default: ;
        endcase
    endtask

    task automatic do_req(input string tag, input logic [31:0] a, input logic io, input logic sec);
        logic [2:0] e;
        e            = model(a, io, sec);
        req_valid    = 1'b1;
        req_addr     = a;
        req_is_io    = io;
        req_from_sec = sec;
        @(negedge clk);
        check(tag, {29'd0, rsp_valid, rsp_forward, rsp_reason}, {29'd0, 1'b1, e});
    endtask

    task automatic idle_check;
        req_valid = 1'b0;
        @(negedge clk);
        check("R2 idle", {29'd0, rsp_valid, rsp_forward, rsp_reason}, 32'd0);
    endtask

    initial begin
        repeat (CLK_PERIOD * 20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R2 reset outputs", {29'd0, rsp_valid, rsp_forward, rsp_reason}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: display-enable is 0 after reset
        cfg_write(0, 32'h3);
        do_req("R1", 32'h000A_0000, 1'b0, 1'b0);
        do_req("R1", 32'h0000_03C4, 1'b1, 1'b0);
        check("R1 reset forward", {31'd0, rsp_forward}, 32'd0);
        idle_check();

        // windows plus display-enable
        cfg_write(1, 32'h8);
        cfg_write(2, 32'h0000_1000);
        cfg_write(3, 32'h0000_1FFF);
        cfg_write(4, 32'h8000_0000);
        cfg_write(5, 32'h8FFF_FFFF);

        // R4/R6/R8/R9: full low-ten-bit sweep with alias bits varied
        for (int i = 0; i < 1024; i++) begin
            logic [31:0] a;
            a = (32'((i * 13) & 63) << 10) | 32'(i);
            do_req("R4 up", a, 1'b1, 1'b0);
            do_req("R6 down", a, 1'b1, 1'b1);
        end
        // upper bits nonzero: not legacy I/O
        for (int i = 0; i < 64; i++) begin
            do_req("R4 upper", 32'h0001_03B0 + 32'(i), 1'b1, 1'b0);
            do_req("R9 upper", 32'h0001_03B0 + 32'(i), 1'b1, 1'b1);
        end
        idle_check();

        // R3/R6: memory around the legacy hole and window edges
        for (int i = 0; i < 80; i++) begin
            logic [31:0] a;
            a = 32'h0009_0000 + 32'(i) * 32'h800;
            do_req("R3 up", a, 1'b0, 1'b0);
            do_req("R6 down", a, 1'b0, 1'b1);
        end
        do_req("R3 lo-1", 32'h0009_FFFF, 1'b0, 1'b0);
        do_req("R3 lo", 32'h000A_0000, 1'b0, 1'b0);
        do_req("R3 hi", 32'h000B_FFFF, 1'b0, 1'b0);
        do_req("R3 hi+1", 32'h000C_0000, 1'b0, 1'b0);
        do_req("R8 base-1", 32'h7FFF_FFFF, 1'b0, 1'b0);
        do_req("R8 base", 32'h8000_0000, 1'b0, 1'b0);
        do_req("R8 limit", 32'h8FFF_FFFF, 1'b0, 1'b0);
        do_req("R8 limit+1", 32'h9000_0000, 1'b0, 1'b0);
        do_req("R9 in", 32'h8000_0000, 1'b0, 1'b1);
        do_req("R9 out", 32'h9000_0000, 1'b0, 1'b1);
        do_req("R9 io in", 32'h0000_1FFF, 1'b1, 1'b1);

        // R5: enable bits gate downstream forwarding
        cfg_write(0, 32'h1);
        do_req("R5 mem off", 32'h000A_8000, 1'b0, 1'b0);
        do_req("R5 mem off win", 32'h8000_1000, 1'b0, 1'b0);
        do_req("R5 io on", 32'h0000_03DF, 1'b1, 1'b0);
        cfg_write(0, 32'h2);
        do_req("R5 io off", 32'h0000_03B0, 1'b1, 1'b0);
        do_req("R5 io off win", 32'h0000_1800, 1'b1, 1'b0);
        do_req("R5 mem on", 32'h000B_0000, 1'b0, 1'b0);
        cfg_write(0, 32'h3);

        // R7: display-enable clear, window over part of the legacy range
        cfg_write(2, 32'h0000_03C0);
        cfg_write(3, 32'h0000_03CF);
        cfg_write(4, 32'h000A_0000);
        cfg_write(5, 32'h000A_FFFF);
        cfg_write(1, 32'h0);
        for (int i = 32'h3A0; i < 32'h400; i++) begin
            do_req("R7 up", 32'(i), 1'b1, 1'b0);
            do_req("R7 down", 32'(i), 1'b1, 1'b1);
        end
        do_req("R7 mem in", 32'h000A_4000, 1'b0, 1'b0);
        do_req("R7 mem out", 32'h000B_4000, 1'b0, 1'b0);
        do_req("R7 mem down", 32'h000B_4000, 1'b0, 1'b1);

        // R10: base above limit empties the window
        cfg_write(1, 32'h8);
        cfg_write(4, 32'h9000_0000);
        cfg_write(5, 32'h8000_0000);
        cfg_write(2, 32'h0000_2000);
        cfg_write(3, 32'h0000_1000);
        for (int i = 0; i < 16; i++) begin
            do_req("R10 mem up", 32'h8000_0000 + 32'(i) * 32'h0100_0000, 1'b0, 1'b0);
            do_req("R10 mem down", 32'h8000_0000 + 32'(i) * 32'h0100_0000, 1'b0, 1'b1);
            do_req("R10 io up", 32'h0000_1000 + 32'(i) * 32'h100, 1'b1, 1'b0);
            do_req("R10 io down", 32'h0000_1000 + 32'(i) * 32'h100, 1'b1, 1'b1);
        end
        do_req("R10 legacy still up", 32'h0000_07C0, 1'b1, 1'b0);
        idle_check();
        idle_check();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule